// File: doc/BRIEF.md
# Comparator Output Conditioner

This block takes the raw one-bit decision of an analog comparator and turns it into a clean, bus-visible level with event flags. The raw bit is first brought into the clock domain through a two-flop synchronizer. A digital glitch filter can then require several consecutive sample strobes to agree before a new level is accepted. The strobe comes either from a programmable divider of the bus clock or from the rising edge of an external sample input that is synchronous to the clock.

The reported level can be inverted, and it can be taken from the unfiltered (synchronized) value instead of the filtered one. Rising and falling transitions of the reported level set sticky flags. Software clears a flag by writing 1 to it. Each flag has its own interrupt enable. Configuration arrives on a plain write-strobe port with a 2-bit address and an 8-bit data word.

Top module: `cmp_out_cond`

## Requirements
- R1: After reset, cmpOut, riseFlag, fallFlag and irq are all 0, and the filter is off (count 0).
- R2: With the filter inactive, a change on rawIn appears on cmpOut after exactly two rising clock edges, through the synchronizer.
- R3: The filter is active only when the count (address 0, bits [2:0]) is greater than 1 and either the external strobe is selected (address 0, bit 3 = 1) or the period (address 1, bits [7:0]) is non-zero. In every other case the output follows the synchronized input as in R2.
- R4: A write to address 1 restarts the divider at 0. The divider then produces one strobe every period+1 clocks. With the filter active and the input stepped in the cycle of that write, the filtered output changes exactly count*(period+1) edges after the write edge.
- R5: A strobed sample that equals the current filtered level restarts the agreement count. A pulse seen by fewer than count strobes never reaches cmpOut and sets no flag.
- R6: When address 0 bit 3 is 1, each rising edge of extSample is one strobe, whatever the period. The filtered output changes on the count-th strobe.
- R7: Address 0 bit 4 = 1 inverts cmpOut.
- R8: Address 0 bit 5 = 1 reports the unfiltered synchronized value instead of the filtered value.
- R9: riseFlag or fallFlag goes high one edge after cmpOut rises or falls, and then stays high.
- R10: Writing 1 to address 3 bit 0 clears riseFlag, and writing 1 to bit 1 clears fallFlag. If a set and a clear meet in the same cycle, the flag stays set.
- R11: irq is high when riseFlag is set and address 2 bit 0 is 1, or when fallFlag is set and address 2 bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawIn | input | 1 | Raw comparator decision, asynchronous |
| extSample | input | 1 | External sample strobe source, synchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| cmpOut | output | 1 | Reported comparator level |
| riseFlag | output | 1 | Sticky rising-edge flag |
| fallFlag | output | 1 | Sticky falling-edge flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted agreement counter or divider phase shows up as cmpOut moving one or more strobe periods too early or too late. The bench therefore pins the exact edge of every filtered transition across a sweep of counts and periods. A wrong activation decision makes cmpOut react after two edges where it should wait, or the reverse. Flag or clear errors are visible on riseFlag, fallFlag and irq one edge after the event.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  parameter int CNT_W = 3;

  typedef struct packed {
    logic             sampleTick;
    logic             filterActive;
    logic             invertOut;
    logic             useRaw;
    logic             clrRise;
    logic             clrFall;
    logic [1:0]       irqEn;
    logic [CNT_W-1:0] needCount;
  } ctrlStrobe_t;
endpackage

// File: rtl/cmp_cond_ctrl.sv
module cmp_cond_ctrl
  import cmp_cond_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [PER_W-1:0] wrData,
  input  logic             extSample,
  output ctrlStrobe_t      ctl
);
  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_PER = 2'd1;
  localparam logic [1:0] ADDR_IEN = 2'd2;
  localparam logic [1:0] ADDR_CLR = 2'd3;

  logic [CNT_W-1:0] cntReg;
  logic             extSel, invReg, rawSel;
  logic [PER_W-1:0] perReg, divCnt;
  logic [1:0]       ienReg;
  logic             extPrev;
  logic             wrCfg, wrPer, wrIen, wrClr, divTick, extTick;

  assign wrCfg = wrEn && (wrAddr == ADDR_CFG);
  assign wrPer = wrEn && (wrAddr == ADDR_PER);
  assign wrIen = wrEn && (wrAddr == ADDR_IEN);
  assign wrClr = wrEn && (wrAddr == ADDR_CLR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
      extSel <= 1'b0;
      invReg <= 1'b0;
      rawSel <= 1'b0;
      perReg <= '0;
      ienReg <= '0;
    end else begin
      if (wrCfg) begin
        cntReg <= wrData[CNT_W-1:0];
        extSel <= wrData[3];
        invReg <= wrData[4];
        rawSel <= wrData[5];
      end
      if (wrPer) perReg <= wrData;
      if (wrIen) ienReg <= wrData[1:0];
    end
  end

  assign divTick = (divCnt == perReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (wrPer)   divCnt <= '0;
    else if (divTick) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extSample;
  end

  assign extTick = extSample && !extPrev;

  always_comb begin
    ctl.sampleTick   = extSel ? extTick : divTick;
    ctl.filterActive = (cntReg > CNT_W'(1)) && (extSel || (perReg != '0));
    ctl.invertOut    = invReg;
    ctl.useRaw       = rawSel;
    ctl.clrRise      = wrClr && wrData[0];
    ctl.clrFall      = wrClr && wrData[1];
    ctl.irqEn        = ienReg;
    ctl.needCount    = cntReg;
  end

  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    wrPer |=> (divCnt == '0)); // R4
  AST_DIV_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!wrPer && divTick) |=> (divCnt == '0)); // R4
  AST_DIV_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrPer && !divTick) |=> (divCnt == $past(divCnt) + 1'b1)); // R4
endmodule

// File: rtl/cmp_cond_dp.sv
module cmp_cond_dp
  import cmp_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rawIn,
  input  ctrlStrobe_t ctl,
  output logic        cmpOut,
  output logic        riseFlag,
  output logic        fallFlag,
  output logic        irq
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLvl, filtLvl, filtOut, repLvl, repPrev;
  logic [CNT_W-1:0]       agreeCnt;
  logic [CNT_W:0]         nextCnt;
  logic                   riseEv, fallEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
  end
  assign syncLvl = syncChain[SYNC_STAGES-1];

  assign nextCnt = {1'b0, agreeCnt} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLvl  <= 1'b0;
      agreeCnt <= '0;
    end else if (!ctl.filterActive) begin
      filtLvl  <= syncLvl;
      agreeCnt <= '0;
    end else if (ctl.sampleTick) begin
      if (syncLvl == filtLvl) begin
        agreeCnt <= '0;
      end else if (nextCnt >= {1'b0, ctl.needCount}) begin
        filtLvl  <= syncLvl;
        agreeCnt <= '0;
      end else begin
        agreeCnt <= nextCnt[CNT_W-1:0];
      end
    end
  end

  assign filtOut = ctl.filterActive ? filtLvl : syncLvl;
  assign repLvl  = (ctl.useRaw ? syncLvl : filtOut) ^ ctl.invertOut;
  assign riseEv  = repLvl && !repPrev;
  assign fallEv  = !repLvl && repPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      repPrev  <= 1'b0;
      riseFlag <= 1'b0;
      fallFlag <= 1'b0;
    end else begin
      repPrev  <= repLvl;
      riseFlag <= riseEv || (riseFlag && !ctl.clrRise);
      fallFlag <= fallEv || (fallFlag && !ctl.clrFall);
    end
  end

  assign cmpOut = repLvl;
  assign irq    = (riseFlag && ctl.irqEn[0]) || (fallFlag && ctl.irqEn[1]);

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.filterActive && !ctl.sampleTick) |=> $stable(filtLvl)); // R5
  AST_RISE_SET: assert property (@(posedge clk) disable iff (!rstN)
    riseEv |=> riseFlag); // R9
  AST_FALL_SET: assert property (@(posedge clk) disable iff (!rstN)
    fallEv |=> fallFlag); // R9
  AST_RISE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrRise && !riseEv) |=> !riseFlag); // R10
  AST_FALL_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrFall && !fallEv) |=> !fallFlag); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (riseFlag && !ctl.clrRise) |=> riseFlag); // R9
endmodule

// File: rtl/cmp_out_cond.sv
module cmp_out_cond
  import cmp_cond_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic             extSample,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [PER_W-1:0] wrData,
  output logic             cmpOut,
  output logic             riseFlag,
  output logic             fallFlag,
  output logic             irq
);
  ctrlStrobe_t ctl;

  cmp_cond_ctrl #(.PER_W(PER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .extSample(extSample), .ctl(ctl)
  );

  cmp_cond_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .ctl(ctl),
    .cmpOut(cmpOut), .riseFlag(riseFlag), .fallFlag(fallFlag), .irq(irq)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (riseFlag || fallFlag)); // R11
endmodule

// File: tb/cmp_out_cond_bench.sv
module cmp_out_cond_bench;
  logic clk = 1'b0, rstN = 1'b0, rawIn = 1'b0, extSample = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic cmpOut, riseFlag, fallFlag, irq;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmp_out_cond u_cmp_out_cond (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .extSample(extSample),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmpOut(cmpOut), .riseFlag(riseFlag), .fallFlag(fallFlag), .irq(irq)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic extPulse();
    extSample = 1'b1; edges(1);
    extSample = 1'b0; edges(2);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit sawHigh;
    edges(2);
    chk(cmpOut, 1'b0, "R1 cmpOut"); chk(riseFlag, 1'b0, "R1 riseFlag");
    chk(fallFlag, 1'b0, "R1 fallFlag"); chk(irq, 1'b0, "R1 irq");
    rstN = 1'b1;
    edges(2);

    // R2: pass-through latency, filter off after reset
    rawIn = 1'b1; edges(1); chk(cmpOut, 1'b0, "R2 after one edge");
    edges(1); chk(cmpOut, 1'b1, "R2 after two edges");
    rawIn = 1'b0; edges(2); chk(cmpOut, 1'b0, "R2 fall after two edges");

    // R3: inactive combinations pass straight through
    wr(2'd0, 8'h03); wr(2'd1, 8'd0);
    rawIn = 1'b1; edges(2); chk(cmpOut, 1'b1, "R3 count3 period0 passes");
    rawIn = 1'b0; edges(4);
    wr(2'd0, 8'h01); wr(2'd1, 8'd5);
    rawIn = 1'b1; edges(2); chk(cmpOut, 1'b1, "R3 count1 passes");
    rawIn = 1'b0; edges(4);
    wr(2'd0, 8'h02);
    rawIn = 1'b1; edges(2); chk(cmpOut, 1'b0, "R3 count2 period5 filters");
    edges(40); chk(cmpOut, 1'b1, "R3 filtered eventually");
    rawIn = 1'b0; edges(40);

    // R4: sweep count and period, exact latency from the period write
    for (int n = 2; n <= 5; n++) begin
      for (int p = 1; p <= 4; p++) begin
        wr(2'd0, 8'(n)); wr(2'd1, 8'd1);
        edges(60);
        wrEn = 1'b1; wrAddr = 2'd1; wrData = 8'(p); rawIn = 1'b1;
        edges(1); wrEn = 1'b0;
        edges(n * (p + 1) - 1);
        chk(cmpOut, 1'b0, $sformatf("R4 n=%0d p=%0d one edge early", n, p));
        edges(1);
        chk(cmpOut, 1'b1, $sformatf("R4 n=%0d p=%0d on time", n, p));
        rawIn = 1'b0; edges(60);
      end
    end

    // R5: pulse shorter than count strobes is suppressed
    wr(2'd0, 8'h03); wr(2'd1, 8'd1); edges(10);
    wr(2'd3, 8'h03);
    sawHigh = 1'b0;
    rawIn = 1'b1; edges(3); rawIn = 1'b0;
    for (int i = 0; i < 20; i++) begin edges(1); if (cmpOut) sawHigh = 1'b1; end
    chk(sawHigh, 1'b0, "R5 glitch blocked");
    chk(riseFlag, 1'b0, "R5 no rise flag");

    // R6: external strobes, period irrelevant
    wr(2'd1, 8'd0); wr(2'd0, 8'h0B);
    rawIn = 1'b1; edges(4);
    extPulse(); chk(cmpOut, 1'b0, "R6 after strobe 1");
    extPulse(); chk(cmpOut, 1'b0, "R6 after strobe 2");
    edges(20); chk(cmpOut, 1'b0, "R6 no strobe no change");
    extPulse(); chk(cmpOut, 1'b1, "R6 after strobe 3");
    rawIn = 1'b0; edges(4);
    extPulse(); extPulse(); chk(cmpOut, 1'b1, "R6 fall needs three");
    extPulse(); chk(cmpOut, 1'b0, "R6 fall on strobe 3");

    // R7: invert
    wr(2'd0, 8'h10); chk(cmpOut, 1'b1, "R7 inverted low input");
    rawIn = 1'b1; edges(2); chk(cmpOut, 1'b0, "R7 inverted high input");
    rawIn = 1'b0; wr(2'd0, 8'h00); edges(4);

    // R8: unfiltered select bypasses an active filter
    wr(2'd1, 8'd255); wr(2'd0, 8'h27);
    rawIn = 1'b1; edges(2); chk(cmpOut, 1'b1, "R8 raw selected");
    wr(2'd0, 8'h07); chk(cmpOut, 1'b0, "R8 filtered still low");
    rawIn = 1'b0; wr(2'd0, 8'h00); edges(4);

    // R9 R10 R11: flags, clear, interrupt
    wr(2'd3, 8'h03); wr(2'd2, 8'h00);
    chk(riseFlag, 1'b0, "R10 cleared before test");
    rawIn = 1'b1; edges(2);
    chk(cmpOut, 1'b1, "R9 level up"); chk(riseFlag, 1'b0, "R9 flag not yet");
    edges(1); chk(riseFlag, 1'b1, "R9 rise flag set");
    chk(irq, 1'b0, "R11 irq masked");
    wr(2'd2, 8'h01); chk(irq, 1'b1, "R11 rise irq enabled");
    rawIn = 1'b0; edges(3);
    chk(fallFlag, 1'b1, "R9 fall flag set"); chk(riseFlag, 1'b1, "R9 rise sticky");
    wr(2'd3, 8'h01);
    chk(riseFlag, 1'b0, "R10 rise cleared"); chk(fallFlag, 1'b1, "R10 fall kept");
    chk(irq, 1'b0, "R11 fall not enabled");
    wr(2'd2, 8'h02); chk(irq, 1'b1, "R11 fall irq enabled");
    wr(2'd3, 8'h02); chk(irq, 1'b0, "R11 irq drops on clear");
    chk(fallFlag, 1'b0, "R10 fall cleared");
    rawIn = 1'b1; edges(2);
    wr(2'd3, 8'h01); chk(riseFlag, 1'b1, "R10 set wins over clear");
    wr(2'd3, 8'h01); chk(riseFlag, 1'b0, "R10 later clear works");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule